// File: doc/BRIEF.md
# Pixel color component extractor

This block turns one packed framebuffer word into an 8-bit red, green and blue triple. Each of the three channels has a select register. The register sets a lowest bit position, a field length and a substitute color. The channel pulls the field out of the pixel word and scales it to eight bits. A format register sets how many bytes of the word form a pixel. Bytes above that count are cleared before any channel looks at the word.

A channel shows its substitute color instead of the extracted field in three cases: its length is zero, the pixel lies outside the visible area, or the upstream fetch reports an underrun. A red substitute of 0xFF therefore turns starved pixels bright red. Results are registered, and a valid flag travels alongside them. The block does not fetch pixels from memory.

Top module: `pix_comp_extract`

## Requirements
- R1: Writes use `cfg_we`/`cfg_addr`/`cfg_wdata`. Address 0 is red, 1 is green and 2 is blue. In each select register the offset is in bits [4:0], the length in bits [11:8] and the substitute color in bits [23:16]. A write affects pixels presented from the next clock cycle onward.
- R2: Address 3 is the format register, holding bytes-per-pixel minus one in bits [4:3]. Pixel bytes above that count read as zero, so zero means only bits [7:0] are used.
- R3: With length L (1..15) and offset O, the raw field is masked-word bits O..O+L-1. Positions beyond bit 31 read as zero.
- R4: A field with L below 8 is placed at the top of the output. Its bits are repeated from its MSB downward to fill the low bits. For example, L=5 with value 10110 gives 0xB5.
- R5: A field with L of 8 or more yields its top 8 bits, raw field bits L-1..L-8.
- R6: A channel whose length field is zero outputs its substitute color.
- R7: When `pix_visible` is low, all channels output their substitute colors.
- R8: When `pix_underrun` is high, all channels output their substitute colors, regardless of visibility or length.
- R9: The outputs for a pixel appear one clock after it is presented. `out_valid` equals `pix_valid` delayed by one clock.
- R10: Reset clears the outputs and `out_valid`, sets every select register to zero and sets the format to four bytes per pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | A pixel slot is presented this cycle |
| pix_word | input | PIX_W | Packed pixel word |
| pix_visible | input | 1 | Pixel lies inside the visible frame |
| pix_underrun | input | 1 | Fetch underrun for this pixel |
| out_valid | output | 1 | Outputs carry a pixel result |
| out_red | output | 8 | Red component |
| out_green | output | 8 | Green component |
| out_blue | output | 8 | Blue component |

## Verification
A pixel presented before a rising edge has its components and `out_valid` due right after that edge. A register write captured at one edge takes effect for the pixel presented in the following cycle. The bench drives every input on the falling edge. It samples the outputs 1 ns after the next rising edge. Before driving, it computes the expected triple from its own copy of the register contents, so each comparison lands exactly one register stage after its stimulus.

// File: rtl/pce_pkg.sv
package pce_pkg;

    localparam int COMP_W = 8;
    localparam int LEN_W  = 4;
    localparam int OFS_W  = 5;
    localparam int NCHAN  = 3;

    localparam logic [1:0] ADDR_RED   = 2'd0;
    localparam logic [1:0] ADDR_GREEN = 2'd1;
    localparam logic [1:0] ADDR_BLUE  = 2'd2;
    localparam logic [1:0] ADDR_FMT   = 2'd3;

    localparam int FMT_LSB = 3;

    typedef struct packed {
        logic [COMP_W-1:0] dflt;
        logic [LEN_W-1:0]  len;
        logic [OFS_W-1:0]  ofs;
    } chan_sel_t;

    function automatic chan_sel_t decode_sel(input logic [31:0] w);
        chan_sel_t s;
        s.dflt = w[23:16];
        s.len  = w[11:8];
        s.ofs  = w[4:0];
        return s;
    endfunction

endpackage

// File: rtl/pce_cfg_regs.sv
module pce_cfg_regs
    import pce_pkg::*;
#(
    parameter int PIX_W = 32,
    localparam int BYTES = PIX_W / 8,
    localparam int BPP_W = $clog2(BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [1:0]            addr,
    input  logic [31:0]           wdata,
    output chan_sel_t [NCHAN-1:0] sel_q,
    output logic [BPP_W-1:0]      bpm1_q
);

    typedef struct packed {
        chan_sel_t [NCHAN-1:0] sel;
        logic [BPP_W-1:0]      bpm1;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic unused_wdata;
    assign unused_wdata = ^{wdata[31:24], wdata[15:12], wdata[7:5]};

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                ADDR_RED:   cfg_d.sel[0] = decode_sel(wdata);
                ADDR_GREEN: cfg_d.sel[1] = decode_sel(wdata);
                ADDR_BLUE:  cfg_d.sel[2] = decode_sel(wdata);
                ADDR_FMT:   cfg_d.bpm1   = wdata[FMT_LSB +: BPP_W];
                default:    cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.sel  <= '0;
            cfg_q.bpm1 <= BPP_W'(BYTES - 1);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign sel_q  = cfg_q.sel;
    assign bpm1_q = cfg_q.bpm1;

endmodule

// File: rtl/pce_byte_mask.sv
module pce_byte_mask #(
    parameter int PIX_W = 32,
    localparam int BYTES = PIX_W / 8,
    localparam int BPP_W = $clog2(BYTES)
) (
    input  logic [BPP_W-1:0] bpm1,
    input  logic [PIX_W-1:0] word_in,
    output logic [PIX_W-1:0] word_out
);

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        logic keep;
        assign keep = (BPP_W'(b) <= bpm1);
        assign word_out[8*b +: 8] = keep ? word_in[8*b +: 8] : 8'h00;
    end

endmodule

// File: rtl/pce_chan.sv
module pce_chan
    import pce_pkg::*;
#(
    parameter int PIX_W = 32,
    localparam int FLD_W = 1 << LEN_W
) (
    input  logic [PIX_W-1:0]  word,
    input  chan_sel_t         sel,
    input  logic              force_dflt,
    output logic [COMP_W-1:0] comp
);

    logic [FLD_W-1:0]  fmask;
    logic [FLD_W-1:0]  field;
    logic [FLD_W-1:0]  wide;
    logic [COMP_W-1:0] rep;
    logic [LEN_W-1:0]  k;

    always_comb begin
        fmask = FLD_W'(({{FLD_W{1'b0}}, 1'b1} << sel.len) - 1'b1);
        field = FLD_W'(word >> sel.ofs) & fmask;
        wide  = field >> (sel.len - LEN_W'(COMP_W));

        rep = '0;
        k   = sel.len - 1'b1;
        for (int i = COMP_W - 1; i >= 0; i--) begin
            rep[i] = field[k];
            k = (k == '0) ? (sel.len - 1'b1) : (k - 1'b1);
        end

        if (force_dflt || sel.len == '0) begin
            comp = sel.dflt;
        end else if (sel.len >= LEN_W'(COMP_W)) begin
            comp = wide[COMP_W-1:0];
        end else begin
            comp = rep;
        end
    end

    logic unused_wide;
    assign unused_wide = ^wide[FLD_W-1:COMP_W];

endmodule

// File: rtl/pix_comp_extract.sv
module pix_comp_extract
    import pce_pkg::*;
#(
    parameter int PIX_W = 32,
    localparam int BYTES = PIX_W / 8,
    localparam int BPP_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_word,
    input  logic              pix_visible,
    input  logic              pix_underrun,
    output logic              out_valid,
    output logic [COMP_W-1:0] out_red,
    output logic [COMP_W-1:0] out_green,
    output logic [COMP_W-1:0] out_blue
);

    typedef struct packed {
        logic                          vld;
        logic [NCHAN-1:0][COMP_W-1:0]  comp;
    } out_t;

    chan_sel_t [NCHAN-1:0]        sel_q;
    logic [BPP_W-1:0]             bpm1_q;
    logic [PIX_W-1:0]             masked;
    logic [NCHAN-1:0][COMP_W-1:0] comp_c;
    logic                         force_dflt;
    out_t                         out_d, out_q;

    pce_cfg_regs #(.PIX_W(PIX_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .sel_q  (sel_q),
        .bpm1_q (bpm1_q)
    );

    pce_byte_mask #(.PIX_W(PIX_W)) u_mask (
        .bpm1     (bpm1_q),
        .word_in  (pix_word),
        .word_out (masked)
    );

    assign force_dflt = !pix_visible || pix_underrun;

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        pce_chan #(.PIX_W(PIX_W)) u_chan (
            .word       (masked),
            .sel        (sel_q[c]),
            .force_dflt (force_dflt),
            .comp       (comp_c[c])
        );
    end

    always_comb begin
        out_d      = out_q;
        out_d.vld  = pix_valid;
        out_d.comp = comp_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.vld;
    assign out_red   = out_q.comp[0];
    assign out_green = out_q.comp[1];
    assign out_blue  = out_q.comp[2];

endmodule

// File: rtl/pce_checker.sv
module pce_checker
    import pce_pkg::*;
#(
    parameter int PIX_W = 32,
    localparam int BYTES = PIX_W / 8,
    localparam int BPP_W = $clog2(BYTES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pix_valid,
    input logic                  pix_visible,
    input logic                  pix_underrun,
    input logic                  out_valid,
    input logic [COMP_W-1:0]     out_red,
    input logic [COMP_W-1:0]     out_green,
    input logic [COMP_W-1:0]     out_blue,
    input chan_sel_t [NCHAN-1:0] sel,
    input logic [BPP_W-1:0]      bpm1
);

    // R10: reset clears the result stage
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_red == '0 && out_green == '0 && out_blue == '0));

    // R9: valid follows the input by one cycle
    assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    assert_idle_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    // R8: underrun forces substitutes on all channels
    assert_underrun_dflt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_underrun) |=>
        (out_red == $past(sel[0].dflt) && out_green == $past(sel[1].dflt)
         && out_blue == $past(sel[2].dflt)));

    // R7: invisible pixels show substitutes
    assert_invisible_dflt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_visible) |=>
        (out_red == $past(sel[0].dflt) && out_green == $past(sel[1].dflt)
         && out_blue == $past(sel[2].dflt)));

    // R6: zero length shows substitute
    assert_zero_len_dflt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && sel[0].len == '0) |=> out_red == $past(sel[0].dflt));

    // R2: a field lying wholly in cleared bytes reads zero
    assert_fmt_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_visible && !pix_underrun && sel[0].len != '0
         && int'(sel[0].ofs) >= 8 * (int'(bpm1) + 1)) |=> out_red == '0);

endmodule

bind pix_comp_extract pce_checker #(.PIX_W(PIX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_valid    (pix_valid),
    .pix_visible  (pix_visible),
    .pix_underrun (pix_underrun),
    .out_valid    (out_valid),
    .out_red      (out_red),
    .out_green    (out_green),
    .out_blue     (out_blue),
    .sel          (sel_q),
    .bpm1         (bpm1_q)
);

// File: tb/pix_comp_extract_tb.sv
module pix_comp_extract_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        pix_valid = 1'b0;
    logic [31:0] pix_word = '0;
    logic        pix_visible = 1'b0;
    logic        pix_underrun = 1'b0;
    logic        out_valid;
    logic [7:0]  out_red, out_green, out_blue;

    int nchk = 0;
    int nerr = 0;
    logic [31:0] m_sel [3];
    logic [1:0]  m_bpm1;

    always #2 clk = ~clk;

    pix_comp_extract u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_word(pix_word),
        .pix_visible(pix_visible), .pix_underrun(pix_underrun),
        .out_valid(out_valid), .out_red(out_red), .out_green(out_green),
        .out_blue(out_blue)
    );

    function automatic logic [7:0] model(input logic [31:0] w, input logic [31:0] s,
                                         input logic [1:0] bpm1, input logic vis,
                                         input logic ur);
        int len = int'(s[11:8]);
        int ofs = int'(s[4:0]);
        logic [31:0] m = w;
        logic [15:0] f = '0;
        logic [7:0]  r = '0;
        if (!vis || ur || len == 0) return s[23:16];
        for (int b = 0; b < 4; b++)
            if (b > int'(bpm1)) m[8*b +: 8] = 8'h00;
        for (int i = 0; i < len; i++)
            if (ofs + i < 32) f[i] = m[ofs + i];
        if (len >= 8) begin
            f = f >> (len - 8);
            return f[7:0];
        end
        for (int i = 0; i < 8; i++) r[7 - i] = f[len - 1 - (i % len)];
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        pix_valid = 1'b0;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        if (a == 2'd3) m_bpm1 = d[4:3];
        else m_sel[a] = d;
    endtask

    task automatic pixel(input string tag, input logic [31:0] w, input logic vis,
                         input logic ur);
        logic [7:0] er, eg, eb;
        @(negedge clk);
        pix_valid = 1'b1; pix_word = w; pix_visible = vis; pix_underrun = ur;
        er = model(w, m_sel[0], m_bpm1, vis, ur);
        eg = model(w, m_sel[1], m_bpm1, vis, ur);
        eb = model(w, m_sel[2], m_bpm1, vis, ur);
        @(posedge clk);
        #1;
        pix_valid = 1'b0;
        check({tag, " R9 valid"}, 32'(out_valid), 32'd1);
        check({tag, " red"},   32'(out_red),   32'(er));
        check({tag, " green"}, 32'(out_green), 32'(eg));
        check({tag, " blue"},  32'(out_blue),  32'(eb));
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        pix_valid = 1'b0;
        @(posedge clk);
        #1;
        check({tag, " R9 idle valid"}, 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int c = 0; c < 3; c++) m_sel[c] = '0;
        m_bpm1 = 2'd3;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset valid", 32'(out_valid), 32'd0);
        check("R10 reset rgb", {8'h0, out_red, out_green, out_blue}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        pixel("R10 zero selects", 32'hFFFF_FFFF, 1'b1, 1'b0);
        cfg_write(2'd0, 32'h00AA_0810);
        cfg_write(2'd1, 32'h0000_0808);
        cfg_write(2'd2, 32'h0000_0800);
        pixel("R1 R3 R10 byte fields", 32'h0012_3456, 1'b1, 1'b0);
        cfg_write(2'd0, 32'h0000_050B);
        pixel("R4 len5 replicate", 32'h0000_B000, 1'b1, 1'b0);
        check("R4 red B5", 32'(out_red), 32'hB5);
        cfg_write(2'd2, 32'h0000_0C00);
        pixel("R5 len12", 32'h0000_0ABC, 1'b1, 1'b0);
        check("R5 blue AB", 32'(out_blue), 32'hAB);
        cfg_write(2'd1, 32'h0037_0008);
        pixel("R6 len0", 32'h1234_5678, 1'b1, 1'b0);
        check("R6 green 37", 32'(out_green), 32'h37);
        pixel("R7 invisible", 32'h1234_5678, 1'b0, 1'b0);
        cfg_write(2'd0, 32'h00FF_0810);
        pixel("R8 underrun", 32'h1234_5678, 1'b1, 1'b1);
        check("R8 red FF", 32'(out_red), 32'hFF);
        cfg_write(2'd0, 32'h0000_081C);
        pixel("R3 past top", 32'hF000_0000, 1'b1, 1'b0);
        check("R3 red 0F", 32'(out_red), 32'h0F);
        cfg_write(2'd3, 32'h0000_0000);
        cfg_write(2'd0, 32'h0000_0808);
        pixel("R2 one byte", 32'hFFFF_FFFF, 1'b1, 1'b0);
        check("R2 red masked", 32'(out_red), 32'h00);
        idle("R9");

        for (int n = 0; n < 800; n++) begin
            int pick = int'($urandom % 10);
            if (pick == 0) cfg_write(2'($urandom % 4), $urandom);
            else if (pick == 1) idle("R9 rnd");
            else pixel("R3 R4 R5 rnd", $urandom, ($urandom % 8) != 0, ($urandom % 10) == 0);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule